// File: doc/BRIEF.md
# Event-Gated Ternary Neuron Accumulator

This block evaluates one neuron whose inputs and weights are each restricted to the values -1, 0 and +1. Activation and weight pairs are fed in one per cycle. A pair does work only when both of its operands are non-zero. In that case the two sign bits are compared with an XNOR, and a signed match count moves up by one on agreement or down by one on disagreement. A pair that holds a zero operand leaves every register in the block untouched. This keeps the datapath quiet for the sparse pairs, which are the majority when the ternary states are spread evenly.

A start pulse opens a new neuron evaluation by clearing the running sum and the count of enabled pairs. A last flag marks the final pair. On that pair the finished sum is compared against a symmetric window of half-width r. The ternary result is +1 above r, -1 below -r, and 0 inside the window, including both edges. The result appears one cycle later together with a single-cycle valid pulse. Raising r makes the output activation sparser. The running sum and the enabled-pair count are also exposed, so that the gating can be compared against a model of the input sparsity.

Top module: `tern_gate_neuron`

## Requirements
- R1: A ternary value is 2 bits {nz, sign} with nz in bit 1. Code 2'b10 is +1 and 2'b11 is -1. Codes 2'b00 and 2'b01 are both zero, so the sign bit is ignored when nz is 0. The output activation only ever uses 2'b00, 2'b10 or 2'b11.
- R2: A cycle without in_valid, or a valid pair with at least one zero operand, leaves sum_o and evt_cnt_o unchanged.
- R3: A valid pair with both operands non-zero adds +1 to sum_o when the sign bits are equal and -1 when they differ. It also increments evt_cnt_o by one. Both changes are visible in the cycle after the pair.
- R4: start clears sum_o and evt_cnt_o, which read zero in the next cycle. A pair presented in the same cycle as start is accumulated onto the cleared value.
- R5: out_valid is high for exactly one cycle: the cycle after a valid pair carrying in_last. At all other times it is low.
- R6: With out_valid high, out_act is +1 when the final sum is greater than THRESH, -1 when it is less than -THRESH, and 0 otherwise. A sum of exactly +THRESH or -THRESH gives 0.
- R7: The sum holds any value from -N_INPUTS to +N_INPUTS without wrapping, so N_INPUTS equal products reach the full magnitude.
- R8: After reset, sum_o and evt_cnt_o are 0, out_valid is 0 and out_act is 2'b00.
- R9: The magnitude of sum_o never exceeds evt_cnt_o, and the two always have the same parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the sum and the enabled-pair count |
| in_valid | input | 1 | A pair is present this cycle |
| in_last | input | 1 | The present pair is the final one of the evaluation |
| act_i | input | 2 | Ternary activation {nz, sign} |
| wgt_i | input | 2 | Ternary weight {nz, sign} |
| out_valid | output | 1 | One-cycle pulse marking a new out_act |
| out_act | output | 2 | Quantized ternary activation {nz, sign} |
| sum_o | output | $clog2(N_INPUTS+1)+1 | Signed running sum of enabled products |
| evt_cnt_o | output | $clog2(N_INPUTS+1) | Number of enabled pairs since start |

## Verification
The bench builds the block with N_INPUTS = 8 and THRESH = 2. With these values a full evaluation of eight equal products drives the 5-bit sum to its extremes of +8 and -8. They also leave room to place sums exactly on the window edges at +2 and -2, and just outside them at +3 and -3. The vectors mix all-zero streams, streams whose zeros carry a set sign bit, cancelling streams and single-pair streams. A start that coincides with a final pair is also exercised, as are idle cycles that carry non-zero operands without in_valid.

// File: rtl/tern_pkg.sv
`timescale 1ns/1ps
package tern_pkg;

   // Ternary code: nz = 0 means zero (sign ignored), else sign selects -1.
   typedef struct packed {
      logic nz;
      logic sgn;
   } tern_t;

   localparam tern_t TERN_ZERO = '{nz: 1'b0, sgn: 1'b0};
   localparam tern_t TERN_POS  = '{nz: 1'b1, sgn: 1'b0};
   localparam tern_t TERN_NEG  = '{nz: 1'b1, sgn: 1'b1};

endpackage

// File: rtl/tern_gate_unit.sv
`timescale 1ns/1ps
module tern_gate_unit
   import tern_pkg::*;
(
   input  logic  valid,
   input  tern_t act,
   input  tern_t wgt,
   output logic  fire,
   output logic  agree
);

   // The event: both operands non-zero on a valid beat.
   assign fire  = valid & act.nz & wgt.nz;
   // Sign comparison is held low while resting so nothing downstream toggles.
   assign agree = fire & ~(act.sgn ^ wgt.sgn);

endmodule

// File: rtl/tern_accum.sv
`timescale 1ns/1ps
module tern_accum #(
   parameter int N_INPUTS = 64,
   localparam int CNT_W = $clog2(N_INPUTS + 1),
   localparam int ACC_W = CNT_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    fire,
   input  logic                    agree,
   output logic signed [ACC_W-1:0] sum_q,
   output logic signed [ACC_W-1:0] sum_nxt,
   output logic [CNT_W-1:0]        evt_q
);

   logic signed [ACC_W-1:0] sum_base;
   logic signed [ACC_W-1:0] step;
   logic [CNT_W-1:0]        evt_base;
   logic [CNT_W-1:0]        evt_nxt;

   always_comb begin
      sum_base = clr ? '0 : sum_q;
      evt_base = clr ? '0 : evt_q;
      if (!fire)      step = '0;
      else if (agree) step = ACC_W'(1);
      else            step = '1;
      sum_nxt = sum_base + step;
      evt_nxt = evt_base + CNT_W'(fire);
   end

   // Registers load only on a clear or an event; resting pairs hold them.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
         evt_q <= '0;
      end else if (clr || fire) begin
         sum_q <= sum_nxt;
         evt_q <= evt_nxt;
      end
   end

   assert_rest_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !fire) |=> ($stable(sum_q) && $stable(evt_q)));

   assert_event_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !clr) |=> (evt_q == $past(evt_q) + CNT_W'(1)));

   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !fire) |=> (sum_q == '0 && evt_q == '0));

   assert_sum_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((sum_q[ACC_W-1] ? -sum_q : sum_q) <= $signed({1'b0, evt_q}))
      && (sum_q[0] == evt_q[0]));

endmodule

// File: rtl/tern_quant.sv
`timescale 1ns/1ps
module tern_quant
   import tern_pkg::*;
#(
   parameter int ACC_W  = 8,
   parameter int THRESH = 4
) (
   input  logic signed [ACC_W-1:0] sum,
   output tern_t                   act
);

   localparam logic signed [ACC_W-1:0] TH_POS = ACC_W'(THRESH);
   localparam logic signed [ACC_W-1:0] TH_NEG = -ACC_W'(THRESH);

   generate
      if (THRESH == 0) begin : g_sign_only
         // Zero-width window: only an exact zero sum maps to zero.
         always_comb begin
            act.nz  = |sum;
            act.sgn = (|sum) & sum[ACC_W-1];
         end
      end else begin : g_window
         always_comb begin
            if (sum > TH_POS)      act = TERN_POS;
            else if (sum < TH_NEG) act = TERN_NEG;
            else                   act = TERN_ZERO;
         end
      end
   endgenerate

endmodule

// File: rtl/tern_gate_neuron.sv
`timescale 1ns/1ps
module tern_gate_neuron
   import tern_pkg::*;
#(
   parameter int N_INPUTS = 64,
   parameter int THRESH   = 4,
   localparam int CNT_W = $clog2(N_INPUTS + 1),
   localparam int ACC_W = CNT_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic                    in_valid,
   input  logic                    in_last,
   input  logic [1:0]              act_i,
   input  logic [1:0]              wgt_i,
   output logic                    out_valid,
   output logic [1:0]              out_act,
   output logic signed [ACC_W-1:0] sum_o,
   output logic [CNT_W-1:0]        evt_cnt_o
);

   generate
      if (N_INPUTS < 1) begin : g_bad_inputs
         $error("tern_gate_neuron: N_INPUTS must be at least 1");
      end
      if (THRESH < 0 || THRESH > N_INPUTS) begin : g_bad_thresh
         $error("tern_gate_neuron: THRESH must lie in 0..N_INPUTS");
      end
   endgenerate

   localparam logic signed [ACC_W-1:0] TH_S = ACC_W'(THRESH);

   tern_t act_t, wgt_t, q_act;
   logic  fire, agree;
   logic signed [ACC_W-1:0] sum_nxt;
   logic  done;

   assign act_t = tern_t'(act_i);
   assign wgt_t = tern_t'(wgt_i);
   assign done  = in_valid & in_last;

   tern_gate_unit u_gate (
      .valid (in_valid),
      .act   (act_t),
      .wgt   (wgt_t),
      .fire  (fire),
      .agree (agree)
   );

   tern_accum #(.N_INPUTS(N_INPUTS)) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .fire    (fire),
      .agree   (agree),
      .sum_q   (sum_o),
      .sum_nxt (sum_nxt),
      .evt_q   (evt_cnt_o)
   );

   tern_quant #(.ACC_W(ACC_W), .THRESH(THRESH)) u_quant (
      .sum (sum_nxt),
      .act (q_act)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_act   <= TERN_ZERO;
      end else begin
         out_valid <= done;
         if (done) out_act <= q_act;
      end
   end

   assert_no_bad_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_act != 2'b01);

   assert_pulse_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid && in_last));

   assert_pulse_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |=> out_valid);

   assert_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (((out_act == 2'b10) == (sum_o > TH_S))
                  && ((out_act == 2'b11) == (sum_o < -TH_S))));

endmodule

// File: tb/tb_tern_gate_neuron.sv
`timescale 1ns/1ps
module tb_tern_gate_neuron;

   localparam int M  = 8;
   localparam int R  = 2;
   localparam int CW = $clog2(M + 1);
   localparam int AW = CW + 1;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, start, in_valid, in_last;
   logic [1:0]    act_i, wgt_i;
   logic          out_valid;
   logic [1:0]    out_act;
   logic signed [AW-1:0] sum_o;
   logic [CW-1:0] evt_cnt_o;

   tern_gate_neuron #(.N_INPUTS(M), .THRESH(R)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .in_last(in_last), .act_i(act_i), .wgt_i(wgt_i),
      .out_valid(out_valid), .out_act(out_act), .sum_o(sum_o),
      .evt_cnt_o(evt_cnt_o)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic chk(input string req, input string what, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
      end
   endtask

   // Product per R1/R3: zero if either nz bit is clear, else +1 on equal signs.
   function automatic int prod(input logic [1:0] a, input logic [1:0] w);
      if (!a[1] || !w[1]) return 0;
      return (a[0] == w[0]) ? 1 : -1;
   endfunction

   typedef struct packed {
      logic [3:0]  len;
      logic [15:0] a;
      logic [15:0] w;
      int          sum;
      int          cnt;
      logic [1:0]  o;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{4'd8, 16'hAAAA, 16'hAAAA,  8, 8, 2'b10},  // R7 full positive
      '{4'd8, 16'hAAAA, 16'hFFFF, -8, 8, 2'b11},  // R7 full negative
      '{4'd8, 16'h0000, 16'hAAAA,  0, 0, 2'b00},  // R2 zero activations
      '{4'd8, 16'h5555, 16'hFFFF,  0, 0, 2'b00},  // R1 zero with sign bit set
      '{4'd4, 16'h002E, 16'h00CE,  2, 2, 2'b00},  // R6 at +r
      '{4'd3, 16'h002E, 16'h002E,  3, 3, 2'b10},  // R6 above +r
      '{4'd2, 16'h000E, 16'h000B, -2, 2, 2'b00},  // R6 at -r
      '{4'd3, 16'h002A, 16'h003F, -3, 3, 2'b11},  // R6 below -r
      '{4'd8, 16'hAAAA, 16'hEEEE,  0, 8, 2'b00},  // R3 cancelling
      '{4'd1, 16'h0003, 16'h0003,  1, 1, 2'b00}   // R3 single pair
   };

   initial begin
      rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
      act_i = 2'b00; wgt_i = 2'b00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R8", "sum after reset", int'(sum_o), 0);
      chk("R8", "count after reset", int'(evt_cnt_o), 0);
      chk("R8", "out_valid after reset", int'(out_valid), 0);
      chk("R8", "out_act after reset", int'(out_act), 0);

      for (int v = 0; v < NV; v++) begin
         int running;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk("R4", "sum after start", int'(sum_o), 0);
         chk("R4", "count after start", int'(evt_cnt_o), 0);
         running = 0;
         for (int i = 0; i < int'(VECS[v].len); i++) begin
            bit lst;
            lst      = (i == int'(VECS[v].len) - 1);
            in_valid = 1'b1;
            in_last  = lst;
            act_i    = VECS[v].a[2*i +: 2];
            wgt_i    = VECS[v].w[2*i +: 2];
            running += prod(act_i, wgt_i);
            @(negedge clk);
            chk("R3", "running sum", int'(sum_o), running);
            if (!lst) begin
               chk("R5", "out_valid mid-stream", int'(out_valid), 0);
            end else begin
               chk("R5", "out_valid after last", int'(out_valid), 1);
               chk("R6", "out_act", int'(out_act), int'(VECS[v].o));
               chk("R7", "final sum", int'(sum_o), VECS[v].sum);
               chk("R2", "enabled count", int'(evt_cnt_o), VECS[v].cnt);
               chk("R9", "sum within count", int'((running < 0 ? -running : running) <= int'(evt_cnt_o)), 1);
            end
         end
         in_valid = 1'b0;
         in_last  = 1'b0;
         @(negedge clk);
         chk("R5", "out_valid pulse ends", int'(out_valid), 0);
      end

      // R2: non-zero operands without in_valid change nothing (last sum was 1, count 1).
      act_i = 2'b10; wgt_i = 2'b10; in_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk("R2", "sum idle with operands", int'(sum_o), 1);
      chk("R2", "count idle with operands", int'(evt_cnt_o), 1);
      chk("R6", "out_act held", int'(out_act), 0);

      // R4: start coincident with a final pair P*N accumulates onto zero.
      start = 1'b1; in_valid = 1'b1; in_last = 1'b1;
      act_i = 2'b10; wgt_i = 2'b11;
      @(negedge clk);
      start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
      chk("R4", "sum start+pair", int'(sum_o), -1);
      chk("R4", "count start+pair", int'(evt_cnt_o), 1);
      chk("R5", "out_valid start+last", int'(out_valid), 1);
      chk("R6", "out_act inside window", int'(out_act), 0);
      @(negedge clk);
      chk("R5", "single pulse", int'(out_valid), 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule